// File: doc/BRIEF.md
# Edge Detect Interrupt Capture Unit

This unit watches the lower group of digital I/O lines for programmed transitions and records which of them moved. It samples the already-synchronised pin levels every clock. Each line has its own edge-direction bit and its own arm bit. A line that is armed and makes a transition in the chosen direction sets a sticky flag. The flags are grouped into one byte per port, and software clears them by writing the byte.

A byte-wide paged access port reaches the direction, arm and flag registers. The surrounding register bank supplies a page number, a byte index, data and read/write strobes. The unit drives a per-port summary that shows which flag bytes are non-zero. It also drives a single level interrupt request formed from that summary. Pin drive, address decoding and host-side dispatch belong to other blocks.

Top module: `ecu_edge_capture`

## Requirements
- R1: After a synchronous reset, every direction, arm and flag bit reads 0, the summary is 0 and the interrupt request is low.
- R2: A write with page 1 stores the data into the direction byte selected by the byte index, and page 2 does the same for the arm byte. Byte index i covers lines 8i to 8i+7. A read strobe returns the addressed byte on the read data port one clock later.
- R3: An armed line whose direction bit is 1 sets its flag on a low-to-high change, and ignores a high-to-low change. An armed line whose direction bit is 0 sets its flag on a high-to-low change, and ignores a low-to-high change. The flag is visible one clock after the pin level changes.
- R4: A line whose arm bit is 0 never sets its flag. Clearing an arm bit leaves a flag that is already set unchanged.
- R5: Once set, a flag stays set until it is cleared. A write with page 3 clears the flags of the indexed byte wherever the written bit is 0 and keeps them wherever it is 1. The write never sets a flag.
- R6: If a qualifying edge arrives in the same clock as a page 3 write that clears that bit, the flag ends up set.
- R7: Summary bit p is 1 exactly when flag byte p is non-zero. The interrupt request is the OR of the summary bits and is a level.
- R8: Writes with page 0, or with byte index 3, change no register. Reads at those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_lvl | input | 24 | Synchronised pin levels, line n on bit n |
| acc_wr | input | 1 | Register write strobe |
| acc_rd | input | 1 | Register read strobe |
| acc_page | input | 2 | Page: 1 direction, 2 arm, 3 flags, 0 none |
| acc_idx | input | 2 | Byte index within the page, 0 to 2 valid |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data, updated one clock after a read strobe |
| pend | output | 3 | Per-port summary of non-zero flag bytes |
| irq | output | 1 | Level interrupt request |

## Verification
A clearing write to a flag byte and a new qualifying edge on a bit of that same byte can meet in one clock. Which of the two wins decides whether an event is lost. The bench forces this collision directly by raising an armed pin in the very clock that writes zero to its flag byte, then reads the byte back and expects the bit set. The random phase mixes pin toggles with writes of random masks to random flag bytes, so the collision recurs many times. A bench model that gives the edge priority judges every read and every summary value.

// File: rtl/ecu_pkg.sv
package ecu_pkg;

    typedef enum logic [1:0] {
        PG_NONE = 2'd0,
        PG_DIR  = 2'd1,
        PG_ARM  = 2'd2,
        PG_FLAG = 2'd3
    } page_e;

    localparam int unsigned MAX_LANE_W = 32;

    // Per-line qualifying-transition detector on a lane up to MAX_LANE_W wide.
    function automatic logic [MAX_LANE_W-1:0] edge_hits(
        input logic [MAX_LANE_W-1:0] prev_lvl,
        input logic [MAX_LANE_W-1:0] cur_lvl,
        input logic [MAX_LANE_W-1:0] dir_rise,
        input logic [MAX_LANE_W-1:0] armed
    );
        logic [MAX_LANE_W-1:0] up;
        logic [MAX_LANE_W-1:0] down;
        up   = ~prev_lvl &  cur_lvl;
        down =  prev_lvl & ~cur_lvl;
        return armed & ((dir_rise & up) | (~dir_rise & down));
    endfunction

    // Flag byte update: write data acts as a keep-mask, new hits always win.
    function automatic logic [MAX_LANE_W-1:0] flag_next(
        input logic [MAX_LANE_W-1:0] cur_flags,
        input logic                  clr_wr,
        input logic [MAX_LANE_W-1:0] keep_mask,
        input logic [MAX_LANE_W-1:0] hits
    );
        logic [MAX_LANE_W-1:0] kept;
        kept = clr_wr ? (cur_flags & keep_mask) : cur_flags;
        return kept | hits;
    endfunction

endpackage

// File: rtl/ecu_port_slice.sv
module ecu_port_slice
    import ecu_pkg::*;
#(
    parameter int unsigned W        = 8,
    parameter int unsigned IDX_W    = 2,
    parameter int unsigned PORT_NUM = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [W-1:0]     lvl,
    input  logic             wr,
    input  page_e            page,
    input  logic [IDX_W-1:0] idx,
    input  logic [W-1:0]     wdata,
    output logic [W-1:0]     dir_q,
    output logic [W-1:0]     arm_q,
    output logic [W-1:0]     flag_q,
    output logic             any_flag
);

    logic [W-1:0] prev_q;
    logic [W-1:0] hits;
    logic         sel;
    logic         wr_dir;
    logic         wr_arm;
    logic         wr_flag;

    assign sel     = (idx == IDX_W'(PORT_NUM));
    assign wr_dir  = wr && sel && (page == PG_DIR);
    assign wr_arm  = wr && sel && (page == PG_ARM);
    assign wr_flag = wr && sel && (page == PG_FLAG);

    assign hits = W'(edge_hits(MAX_LANE_W'(prev_q), MAX_LANE_W'(lvl),
                               MAX_LANE_W'(dir_q), MAX_LANE_W'(arm_q)));

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= lvl;
            dir_q  <= '0;
            arm_q  <= '0;
            flag_q <= '0;
        end else begin
            prev_q <= lvl;
            if (wr_dir) dir_q <= wdata;
            if (wr_arm) arm_q <= wdata;
            flag_q <= W'(flag_next(MAX_LANE_W'(flag_q), wr_flag,
                                   MAX_LANE_W'(wdata), MAX_LANE_W'(hits)));
        end
    end

    assign any_flag = |flag_q;

    // R3: a qualifying edge is latched in the next cycle
    p_edge_latched_r3: assert property (@(posedge clk) disable iff (rst)
        (hits != '0) |=> ((flag_q & $past(hits)) == $past(hits)));

    // R4: a disarmed line never gains a flag
    p_disarmed_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(arm_q)) == '0));

    // R5: flags persist when no clearing write targets this byte
    p_flag_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        !wr_flag |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

    // R5: a clearing write never sets a bit by itself
    p_clear_no_set_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_flag && hits == '0) |=> ((flag_q & ~$past(flag_q)) == '0));

    // R2: direction write lands in the register
    p_dir_written_r2: assert property (@(posedge clk) disable iff (rst)
        wr_dir |=> (dir_q == $past(wdata)));

endmodule

// File: rtl/ecu_read_mux.sv
module ecu_read_mux
    import ecu_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 3,
    parameter int unsigned W         = 8,
    parameter int unsigned IDX_W     = 2
) (
    input  page_e                    page,
    input  logic [IDX_W-1:0]         idx,
    input  logic [NUM_PORTS*W-1:0]   dir_all,
    input  logic [NUM_PORTS*W-1:0]   arm_all,
    input  logic [NUM_PORTS*W-1:0]   flag_all,
    output logic [W-1:0]             rd_byte
);

    always_comb begin
        rd_byte = '0;
        for (int p = 0; p < int'(NUM_PORTS); p++) begin
            if (idx == IDX_W'(p)) begin
                unique case (page)
                    PG_DIR:  rd_byte = dir_all[p*W +: W];
                    PG_ARM:  rd_byte = arm_all[p*W +: W];
                    PG_FLAG: rd_byte = flag_all[p*W +: W];
                    default: rd_byte = '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/ecu_edge_capture.sv
module ecu_edge_capture
    import ecu_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 3,
    parameter int unsigned PORT_W    = 8,
    localparam int unsigned LINES    = NUM_PORTS * PORT_W,
    localparam int unsigned IDX_W    = $clog2(NUM_PORTS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LINES-1:0]  pin_lvl,
    input  logic              acc_wr,
    input  logic              acc_rd,
    input  logic [1:0]        acc_page,
    input  logic [IDX_W-1:0]  acc_idx,
    input  logic [PORT_W-1:0] acc_wdata,
    output logic [PORT_W-1:0] acc_rdata,
    output logic [NUM_PORTS-1:0] pend,
    output logic              irq
);

    page_e                  page;
    logic [LINES-1:0]       dir_all;
    logic [LINES-1:0]       arm_all;
    logic [LINES-1:0]       flag_all;
    logic [PORT_W-1:0]      rd_byte;

    assign page = page_e'(acc_page);

    for (genvar p = 0; p < int'(NUM_PORTS); p++) begin : g_port
        ecu_port_slice #(
            .W        (PORT_W),
            .IDX_W    (IDX_W),
            .PORT_NUM (p)
        ) u_slice (
            .clk      (clk),
            .rst      (rst),
            .lvl      (pin_lvl[p*PORT_W +: PORT_W]),
            .wr       (acc_wr),
            .page     (page),
            .idx      (acc_idx),
            .wdata    (acc_wdata),
            .dir_q    (dir_all[p*PORT_W +: PORT_W]),
            .arm_q    (arm_all[p*PORT_W +: PORT_W]),
            .flag_q   (flag_all[p*PORT_W +: PORT_W]),
            .any_flag (pend[p])
        );
    end

    ecu_read_mux #(
        .NUM_PORTS (NUM_PORTS),
        .W         (PORT_W),
        .IDX_W     (IDX_W)
    ) u_rmux (
        .page     (page),
        .idx      (acc_idx),
        .dir_all  (dir_all),
        .arm_all  (arm_all),
        .flag_all (flag_all),
        .rd_byte  (rd_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) acc_rdata <= '0;
        else if (acc_rd) acc_rdata <= rd_byte;
    end

    assign irq = |pend;

    // R8: writes to page 0 leave the whole register set unchanged
    p_base_page_inert_r8: assert property (@(posedge clk) disable iff (rst)
        (acc_wr && page == PG_NONE) |=>
            (dir_all == $past(dir_all) && arm_all == $past(arm_all)));

    // R2: read data holds between read strobes
    p_rdata_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !acc_rd |=> $stable(acc_rdata));

    // R7: with no flags set, no interrupt request
    p_irq_needs_flag_r7: assert property (@(posedge clk) disable iff (rst)
        (flag_all == '0) |-> !irq);

endmodule

// File: tb/sim_ecu_edge_capture.sv
`timescale 1ns/1ps
module sim_ecu_edge_capture;
    localparam int NP = 3;
    localparam int W  = 8;
    localparam int L  = NP * W;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst;
    logic [L-1:0]  pins;
    logic          wr, rd;
    logic [1:0]    page, idx;
    logic [W-1:0]  wdata;
    logic [W-1:0]  rdata;
    logic [NP-1:0] pend;
    logic          irq;

    int checks = 0;
    int errors = 0;

    logic [L-1:0] dir_m, arm_m, flag_m, prev_m;

    ecu_edge_capture u0 (
        .clk(clk), .rst(rst), .pin_lvl(pins), .acc_wr(wr), .acc_rd(rd),
        .acc_page(page), .acc_idx(idx), .acc_wdata(wdata),
        .acc_rdata(rdata), .pend(pend), .irq(irq)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] model_read(input logic [1:0] pg, input logic [1:0] ix);
        if (ix == 2'd3 || pg == 2'd0) return '0;
        case (pg)
            2'd1:    return dir_m[int'(ix)*W +: W];
            2'd2:    return arm_m[int'(ix)*W +: W];
            default: return flag_m[int'(ix)*W +: W];
        endcase
    endfunction

    // Called at a falling edge: drive, step one clock, compare at next falling edge.
    task automatic tick(input logic [L-1:0] p, input logic w, input logic [1:0] pg,
                        input logic [1:0] ix, input logic [W-1:0] d, input logic r,
                        input string rtag);
        logic [L-1:0]  hits, n_dir, n_arm, n_flag;
        logic [W-1:0]  rexp;
        logic [NP-1:0] pexp;
        pins = p; wr = w; page = pg; idx = ix; wdata = d; rd = r;
        hits  = arm_m & ((dir_m & ~prev_m & p) | (~dir_m & prev_m & ~p));
        rexp  = model_read(pg, ix);
        n_dir = dir_m; n_arm = arm_m; n_flag = flag_m;
        if (w && ix != 2'd3) begin
            case (pg)
                2'd1: n_dir[int'(ix)*W +: W] = d;
                2'd2: n_arm[int'(ix)*W +: W] = d;
                2'd3: n_flag[int'(ix)*W +: W] = flag_m[int'(ix)*W +: W] & d;
                default: ;
            endcase
        end
        n_flag = n_flag | hits;
        @(posedge clk);
        @(negedge clk);
        dir_m = n_dir; arm_m = n_arm; flag_m = n_flag; prev_m = p;
        wr = 1'b0; rd = 1'b0;
        if (r) check(rdata == rexp, rtag, 32'(rdata), 32'(rexp));
        for (int k = 0; k < NP; k++) pexp[k] = |flag_m[k*W +: W];
        check(pend == pexp, "R7 pend", 32'(pend), 32'(pexp));
        check(irq == (|pexp), "R7 irq", 32'(irq), 32'(|pexp));
    endtask

    task automatic wreg(input logic [1:0] pg, input logic [1:0] ix, input logic [W-1:0] d);
        tick(pins, 1'b1, pg, ix, d, 1'b0, "");
    endtask

    task automatic rreg(input logic [1:0] pg, input logic [1:0] ix, input string tag);
        tick(pins, 1'b0, pg, ix, '0, 1'b1, tag);
    endtask

    initial begin
        #(5.0 * 190000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        rst = 1'b1; pins = '0; wr = 0; rd = 0; page = 0; idx = 0; wdata = 0;
        dir_m = '0; arm_m = '0; flag_m = '0; prev_m = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check(pend == '0 && irq == 1'b0, "R1 outputs", {pend, irq}, 0);
        for (int pg = 1; pg < 4; pg++)
            for (int ix = 0; ix < 3; ix++) rreg(2'(pg), 2'(ix), "R1");

        // R2: direction and arm write / readback
        wreg(2'd1, 2'd1, 8'hA5); rreg(2'd1, 2'd1, "R2");
        wreg(2'd2, 2'd2, 8'h3C); rreg(2'd2, 2'd2, "R2");
        rreg(2'd1, 2'd0, "R2");
        wreg(2'd1, 2'd1, 8'h00); wreg(2'd2, 2'd2, 8'h00);

        // R3: rising on port 0
        wreg(2'd1, 2'd0, 8'hFF); wreg(2'd2, 2'd0, 8'hFF);
        tick(pins | 24'h000001, 0, 0, 0, 0, 0, "");
        rreg(2'd3, 2'd0, "R3");
        // R3: falling on port 1, rising ignored
        wreg(2'd1, 2'd1, 8'h00); wreg(2'd2, 2'd1, 8'hFF);
        tick(pins | 24'h000100, 0, 0, 0, 0, 0, "");
        rreg(2'd3, 2'd1, "R3");
        tick(pins & ~24'h000100, 0, 0, 0, 0, 0, "");
        rreg(2'd3, 2'd1, "R3");

        // R4: disarmed port 2 stays quiet; disarming keeps latched flags
        tick(pins ^ 24'hFF0000, 0, 0, 0, 0, 0, "");
        tick(pins ^ 24'hFF0000, 0, 0, 0, 0, 0, "");
        rreg(2'd3, 2'd2, "R4");
        wreg(2'd2, 2'd0, 8'h00);
        rreg(2'd3, 2'd0, "R4");
        tick(pins | 24'h000002, 0, 0, 0, 0, 0, "");
        rreg(2'd3, 2'd0, "R4");

        // R5: sticky flags and keep-mask clearing
        wreg(2'd2, 2'd0, 8'hFF);
        tick(pins | 24'h00000C, 0, 0, 0, 0, 0, "");
        rreg(2'd3, 2'd0, "R5");
        wreg(2'd3, 2'd0, 8'hFB); rreg(2'd3, 2'd0, "R5");
        wreg(2'd3, 2'd0, 8'hFF); rreg(2'd3, 2'd0, "R5");
        wreg(2'd3, 2'd0, 8'h00); rreg(2'd3, 2'd0, "R5");
        wreg(2'd3, 2'd1, 8'h00);

        // R6: edge collides with a clearing write
        tick(pins | 24'h000010, 1, 2'd3, 2'd0, 8'h00, 0, "");
        rreg(2'd3, 2'd0, "R6");

        // R8: inert addresses
        wreg(2'd0, 2'd0, 8'hFF); wreg(2'd0, 2'd2, 8'h55);
        wreg(2'd1, 2'd3, 8'hFF); wreg(2'd2, 2'd3, 8'hFF); wreg(2'd3, 2'd3, 8'h00);
        for (int pg = 1; pg < 4; pg++)
            for (int ix = 0; ix < 3; ix++) rreg(2'(pg), 2'(ix), "R8");
        rreg(2'd0, 2'd1, "R8");
        rreg(2'd1, 2'd3, "R8");
        for (int ix = 0; ix < 3; ix++) wreg(2'd3, 2'(ix), 8'h00);

        // Random phase
        for (int n = 0; n < 4000; n++) begin
            logic [L-1:0] np;
            logic         w, r;
            np = pins ^ (L'($urandom) & L'($urandom) & L'($urandom));
            w  = ($urandom % 4) == 0;
            r  = ($urandom % 3) == 0;
            tick(np, w, 2'($urandom), 2'($urandom), 8'($urandom), r, "R2 random");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule